// File: doc/BRIEF.md
# Serial Data Register for a Byte-Wide SPI Master

This block is the byte register that sits between an 8-bit processor bus and the serial lines of an SPI master. A bus write parallel-loads a transmit stage, and that write starts a transfer. The sequencer outside the block then produces a gated shift clock. On each rising edge of that clock one bit leaves on MOSI, most significant bit first, and one bit is captured from MISO into a receive stage, also most significant bit first.

Received bits do not reach the bus directly. They stay in the receive shift stage until the sequencer pulses a latch strobe. The strobe copies the whole stage into a holding register in one system clock cycle, and bus reads return that holding register. If the strobe is missed, a read returns the previous byte. Reset clears the receive shift stage but leaves the holding register alone, so its contents after power-up are undefined.

The shift clock is an ordinary input that is sampled on the system clock. A shift event is a low-to-high change seen between two consecutive system clock samples, so each level of the shift clock must last at least one system clock cycle. Bit counting, clock generation and sequencing are done outside the block. The bus side is a plain select/direction interface with no back-pressure: every selected cycle is accepted at once.

Top module: `spi_data_reg`

## Requirements
- R1: A bus cycle with `cs`=1 and `rw_n`=0 loads `wr_data` into the transmit stage at that clock edge, and `mosi` shows `wr_data[7]` from the next cycle.
- R2: On each shift event (with `shift_inh`=0 and no bus write), the transmit stage moves one place toward its most significant end and a 0 enters at bit 0. `mosi` always shows the current bit 7, so after 8 events the stage is all zeros.
- R3: On the same shift event, the receive stage moves one place toward its most significant end and `miso` enters at bit 0. After 8 events the first bit captured sits at bit 7.
- R4: While `shift_inh`=1, shift events change neither stage.
- R5: A bus write in the same cycle as a shift event loads the transmit stage and shifts neither stage.
- R6: A `rx_latch` pulse copies the receive stage into the holding register at that clock edge. Without a pulse, the holding register and the read value keep their previous byte.
- R7: `rd_data` equals the holding register while `cs`=1 and `rw_n`=1, and is all zeros otherwise.
- R8: Bus reads leave both stages unchanged.
- R9: Reset clears the receive stage to zero and leaves the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register select |
| rw_n | input | 1 | 1 = read, 0 = write |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Bus read data, zero when not reading |
| sclk | input | 1 | Gated shift clock, sampled on `clk` |
| shift_inh | input | 1 | Shift inhibit, active high |
| rx_latch | input | 1 | Copy receive stage to holding register |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
If the transmit stage goes wrong, `mosi` is wrong in the very next system cycle, because it shows bit 7 directly. A receive-stage fault stays hidden until the next latch strobe and only shows on the next selected read, so a bad bit can go unseen for a whole transfer. A holding register that loses or gains data outside a strobe shows up on any read between strobes, and the reset test in particular reads it right after reset. The bench therefore compares `mosi` on every cycle and `rd_data` on every read against a behavioural model. It places reads between transfers, inside transfers and around reset.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  localparam logic BUS_RD = 1'b1;
  localparam logic BUS_WR = 1'b0;

  function automatic logic [7:0] shl_in(input logic [7:0] v, input logic b);
    return {v[6:0], b};
  endfunction
endpackage

// File: rtl/spi_dr_edge.sv
module spi_dr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;

  p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/spi_dr_tx.sv
module spi_dr_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         step,
  output logic         sout
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (load)      sr_q <= din;
    else if (step) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign sout = sr_q[W-1];

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sout == $past(din[W-1])));
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(sout));
endmodule

// File: rtl/spi_dr_rx.sv
module spi_dr_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         sin,
  input  logic         latch,
  output logic [W-1:0] hold
);
  logic [W-1:0] sr_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sr_q <= '0;
    else if (step) sr_q <= {sr_q[W-2:0], sin};
  end

  always_ff @(posedge clk) begin
    if (latch) hold_q <= sr_q;
  end

  assign hold = hold_q;

  p_rx_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(sr_q));
  p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (hold_q == $past(sr_q)));
  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(hold_q));
endmodule

// File: rtl/spi_data_reg.sv
module spi_data_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         rw_n,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         sclk,
  input  logic         shift_inh,
  input  logic         rx_latch,
  output logic         mosi,
  input  logic         miso
);
  import spi_dr_pkg::*;

  logic         rise;
  logic         bus_wr;
  logic         bus_rd;
  logic         step;
  logic [W-1:0] hold;

  assign bus_wr = cs && (rw_n == BUS_WR);
  assign bus_rd = cs && (rw_n == BUS_RD);
  assign step   = rise && !shift_inh && !bus_wr;

  spi_dr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(rise)
  );

  spi_dr_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(bus_wr), .din(wr_data),
    .step(step), .sout(mosi)
  );

  spi_dr_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .step(step), .sin(miso),
    .latch(rx_latch), .hold(hold)
  );

  assign rd_data = bus_rd ? hold : '0;

  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && rise) |=> (mosi == $past(wr_data[W-1])));
  p_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_inh && !bus_wr) |=> $stable(mosi));
  p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (rd_data == '0));
endmodule

// File: tb/spi_data_reg_test.sv
`timescale 1ns/1ps
module spi_data_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rw_n = 1'b1, sclk = 1'b0, shift_inh = 1'b0;
  logic       rx_latch = 1'b0, miso = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       mosi;

  int checks = 0, errors = 0;
  string tag = "R1";

  bit [7:0] m_tx, m_rx, m_hold;
  bit m_tx_known = 0, m_hold_known = 0, m_prev = 0;

  always #2.5 clk = ~clk;

  spi_data_reg uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw_n(rw_n), .wr_data(wr_data),
    .rd_data(rd_data), .sclk(sclk), .shift_inh(shift_inh),
    .rx_latch(rx_latch), .mosi(mosi), .miso(miso)
  );

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated at each rising clk
  always @(posedge clk) begin
    bit edge_seen, wr;
    wr = cs && !rw_n;
    edge_seen = sclk && !m_prev;
    if (rx_latch) begin m_hold = m_rx; m_hold_known = 1; end
    if (!rst_n) begin
      m_rx = 0; m_prev = 0;
    end else begin
      if (wr) begin m_tx = wr_data; m_tx_known = 1; end
      else if (edge_seen && !shift_inh) begin
        m_tx = m_tx << 1;
        m_rx = (m_rx << 1) | 8'(miso);
      end
      m_prev = sclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_tx_known) check({tag, " mosi"}, {7'd0, mosi}, {7'd0, m_tx[7]});
      if (!(cs && rw_n)) check("R7 idle bus", rd_data, 8'h00);
      else if (m_hold_known) check({tag, " read"}, rd_data, m_hold);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [7:0] b);
    cs = 1; rw_n = 0; wr_data = b; tick(1); cs = 0; rw_n = 1;
  endtask

  task automatic bus_read(output logic [7:0] b);
    cs = 1; rw_n = 1; tick(1);
    #1 b = rd_data;
    cs = 0;
  endtask

  task automatic sbit(input logic v);
    miso = v; sclk = 1; tick(2); sclk = 0; tick(2);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input bit do_latch);
    bus_write(tx);
    for (int i = 7; i >= 0; i--) sbit(rx[i]);
    if (do_latch) begin rx_latch = 1; tick(1); rx_latch = 0; end
  endtask

  initial begin
    logic [7:0] r;
    fork
      begin #200000; errors++; $display("FAIL watchdog: got timeout expected finish"); end
      begin
        tick(3); rst_n = 1; tick(2);
        tag = "R7"; check("R7 reset idle", rd_data, 8'h00);
        tag = "R2"; xfer(8'hA5, 8'h3C, 1);
        tag = "R3"; bus_read(r); check("R3 MSB-first capture", r, 8'h3C);
        check("R2 tx drained", {7'd0, mosi}, 8'h00);
        tag = "R6"; xfer(8'h5A, 8'hC3, 0);
        bus_read(r); check("R6 stale without latch", r, 8'h3C);
        rx_latch = 1; tick(1); rx_latch = 0;
        bus_read(r); check("R6 after latch", r, 8'hC3);
        tag = "R4"; bus_write(8'hF0); shift_inh = 1;
        for (int i = 0; i < 4; i++) sbit(1'b1);
        shift_inh = 0;
        check("R4 mosi frozen", {7'd0, mosi}, 8'h01);
        rx_latch = 1; tick(1); rx_latch = 0;
        bus_read(r); check("R4 rx frozen", r, 8'hC3);
        tag = "R5"; sclk = 1; cs = 1; rw_n = 0; wr_data = 8'h0F; miso = 1;
        tick(1); cs = 0; rw_n = 1; tick(1); sclk = 0; tick(2);
        check("R5 load wins", {7'd0, mosi}, 8'h00);
        tag = "R8"; bus_write(8'h96);
        for (int i = 0; i < 8; i++) begin sbit(i[0]); bus_read(r); end
        rx_latch = 1; tick(1); rx_latch = 0;
        bus_read(r); check("R8 reads harmless", r, 8'h55);
        tag = "R9"; rst_n = 0; tick(2); rst_n = 1; tick(1);
        bus_read(r); check("R9 hold kept", r, 8'h55);
        rx_latch = 1; tick(1); rx_latch = 0;
        bus_read(r); check("R9 rx cleared", r, 8'h00);
        tag = "R1"; bus_write(8'h80); check("R1 load msb", {7'd0, mosi}, 8'h01);
        bus_write(8'h7F); check("R1 load msb zero", {7'd0, mosi}, 8'h00);
        tick(2);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule